// File: doc/BRIEF.md
# Configuration Bitstream Framer

This block turns a configuration image into the serial bit stream that a chain of programmable devices loads from, one bit per clock. After a start pulse it sends a header, then the framed program data for every device in the chain, then a closing run of ones. The header holds a synchronisation pattern and a 24-bit length count, which the block works out from the configuration it was started with. Each data frame is wrapped in a low start bit and three high stop bits. A postamble of four ones closes the frames of each device.

Frame contents come from an upstream source over a ready/valid handshake, one word per frame. The block never stores the image. When a word is not offered in time, the line holds high until one arrives. The serial output changes on the falling clock edge, so the receiving device can sample it on the rising edge. Busy and done levels report progress.

The operating values are: data field width of 1 or more, frame count of 1 or more, device count of 1 or more, and K from 2 to 4. Other values are outside the operating range.

Top module: `cfg_bitstream_framer`

## Requirements
- R1: After reset and whenever no stream is in progress, `sdo_o` is 1, `busy_o` is 0 and `in_ready_o` is 0. `done_o` is 0 after reset.
- R2: A stream opens with eight 1 bits followed by the code bits 0, 0, 1, 0, in that order.
- R3: The 24-bit length count follows the code, most significant bit first, and is followed by four 1 bits.
- R4: The length count equals R − K. R is the sum of the 40 header bits, the device count times (frame count × (data width + 4) + 4), and one bit per device, rounded up to the next multiple of 8. The value appears on `len_count_o` from the first stream cycle on.
- R5: When the round-up increment in R4 is smaller than K (this includes an increment of 0), 8 is added to R before K is subtracted.
- R6: Each frame is sent as a 0, then bits `in_data_i[w-1]` down to `in_data_i[0]` of its word (w = data width; higher bits are ignored), then three 1 bits.
- R7: Each device gets the configured number of frames followed by four 1 bits. This group repeats once per device, with the frame words consumed in order.
- R8: A frame word is consumed on a cycle where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` rises only in the bit period just before a frame's start bit. Each further cycle spent waiting for a word emits exactly one extra 1 before that start bit.
- R9: `sdo_o` changes only on the falling clock edge. Each bit holds across the following rising edge, and the first header bit appears on the falling edge after the rising edge that accepts `start_i`.
- R10: Without stalls, `busy_o` stays 1 for exactly 40 + devices × (frames × (width + 4) + 4) cycles. `done_o` rises as `busy_o` falls and is cleared by the next accepted start.
- R11: `start_i` and changes on the configuration inputs are ignored while `busy_o` is 1. The stream in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only while idle |
| cfg_dw_i | input | 8 | Data field width in bits (1..128) |
| cfg_frames_i | input | 16 | Frames per device (1 or more) |
| cfg_devs_i | input | 4 | Devices in the chain (1 or more) |
| cfg_k_i | input | 3 | Start-up compensation K (2..4) |
| in_valid_i | input | 1 | Frame word offered |
| in_data_i | input | 128 | Frame word; field in bits w-1..0 |
| in_ready_o | output | 1 | Frame word requested |
| sdo_o | output | 1 | Serial configuration stream |
| busy_o | output | 1 | Stream in progress |
| done_o | output | 1 | Last stream completed |
| len_count_o | output | 24 | Length count of the current stream |

## Verification
Each bit of the stream is due on the falling edge of the cycle in which it is produced. The bench reads `sdo_o` twice per bit: 2 ns before each rising edge and 2 ns after it. Both readings must equal the bit expected at that position, so a bit that moves at the rising edge is caught.

The length count is due one cycle after the start pulse is accepted. `busy_o` falls, and `done_o` rises, in the same cycle that the last postamble bit is read.

Handshake stalls are planned per frame. The expected stream inserts one extra 1 per wait cycle, counted from the cycle in which the bench sees `in_ready_o` high at the falling edge.

// File: rtl/cfg_framer_pkg.sv
package cfg_framer_pkg;

    // fixed framing widths of the stream
    localparam int SEP_BITS  = 4;
    localparam int STOP_BITS = 3;
    localparam int POST_BITS = 4;
    localparam int CODE_BITS = 4;

    // synchronisation code, sent bit 3 first
    localparam logic [CODE_BITS-1:0] SYNC_CODE = 4'b0010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_LEN,
        ST_SEP,
        ST_WAIT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_POST
    } seq_state_e;

endpackage

// File: rtl/cfg_len_calc.sv
module cfg_len_calc #(
    parameter int DWW     = 8,
    parameter int FRAME_W = 16,
    parameter int DEV_W   = 4,
    parameter int LC_W    = 24,
    parameter int HDR_N   = 40
) (
    input  logic [DWW-1:0]     dw_i,
    input  logic [FRAME_W-1:0] frames_i,
    input  logic [DEV_W-1:0]   devs_i,
    input  logic [2:0]         k_i,
    output logic [LC_W-1:0]    len_o
);

    localparam int AW = 48;

    logic [AW-1:0] dw_x, fr_x, dv_x, k_x;
    logic [AW-1:0] per_dev, raw, rnd, adj;

    always_comb begin
        dw_x    = AW'(dw_i);
        fr_x    = AW'(frames_i);
        dv_x    = AW'(devs_i);
        k_x     = AW'(k_i);
        // bits of one device's frames plus its postamble
        per_dev = fr_x * (dw_x + AW'(4)) + AW'(POST_ADD);
        // header, all devices, one extra clock per device
        raw     = AW'(HDR_N) + dv_x * per_dev + dv_x;
        rnd     = (raw + AW'(7)) & ~AW'(7);
        // keep at least K clocks of margin inside the rounding
        adj     = ((rnd - raw) < k_x) ? (rnd + AW'(8)) : rnd;
        len_o   = LC_W'(adj - k_x);
    end

    localparam int POST_ADD = cfg_framer_pkg::POST_BITS;

endmodule

// File: rtl/cfg_sdo_stage.sv
module cfg_sdo_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic sdo_o
);

    logic sdo_d, sdo_q;

    always_comb begin
        sdo_d = bit_i;
    end

    // launched on the falling edge: receiver samples on the rising edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b1;
        else        sdo_q <= sdo_d;
    end

    assign sdo_o = sdo_q;

endmodule

// File: rtl/cfg_bit_sequencer.sv
module cfg_bit_sequencer
    import cfg_framer_pkg::*;
#(
    parameter int DW_MAX  = 128,
    parameter int FRAME_W = 16,
    parameter int DEV_W   = 4,
    parameter int LC_W    = 24,
    parameter int DUMMY_N = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [$clog2(DW_MAX+1)-1:0] cfg_dw_i,
    input  logic [FRAME_W-1:0]         cfg_frames_i,
    input  logic [DEV_W-1:0]           cfg_devs_i,
    input  logic [2:0]                 cfg_k_i,
    input  logic [LC_W-1:0]            len_i,
    input  logic                       in_valid_i,
    input  logic [DW_MAX-1:0]          in_data_i,
    output logic                       in_ready_o,
    output logic                       bit_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [$clog2(DW_MAX+1)-1:0] lat_dw_o,
    output logic [FRAME_W-1:0]         lat_frames_o,
    output logic [DEV_W-1:0]           lat_devs_o,
    output logic [2:0]                 lat_k_o
);

    localparam int DWW   = $clog2(DW_MAX + 1);
    localparam int PRE_N = DUMMY_N + CODE_BITS;
    localparam int CMAX  = (DW_MAX > LC_W) ? ((DW_MAX > PRE_N) ? DW_MAX : PRE_N)
                                           : ((LC_W > PRE_N) ? LC_W : PRE_N);
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] fidx;
        logic [DEV_W-1:0]   didx;
        logic [DW_MAX-1:0]  word;
        logic [DWW-1:0]     dw;
        logic [FRAME_W-1:0] fr;
        logic [DEV_W-1:0]   dv;
        logic [2:0]         k;
        logic               done;
    } seq_t;

    seq_t q, d;

    logic                 last, more_frames, more_devs, fetch, take;
    logic [DW_MAX-1:0]    word_sh;
    logic [LC_W-1:0]      len_sh;
    logic [CODE_BITS-1:0] code_sh;

    always_comb begin
        last        = (q.cnt == '0);
        more_frames = (q.fidx != (q.fr - FRAME_W'(1)));
        more_devs   = (q.didx != (q.dv - DEV_W'(1)));
        // a word is requested only in the bit period before a start bit
        fetch = ((q.st == ST_SEP)  && last)
             || ((q.st == ST_STOP) && last && more_frames)
             || ((q.st == ST_POST) && last && more_devs)
             ||  (q.st == ST_WAIT);
        take  = fetch && in_valid_i;

        word_sh = q.word >> q.cnt;
        len_sh  = len_i >> q.cnt;
        code_sh = SYNC_CODE >> q.cnt;

        bit_o = 1'b1;
        case (q.st)
            ST_PRE:   if (q.cnt < CNT_W'(CODE_BITS)) bit_o = code_sh[0];
            ST_LEN:   bit_o = len_sh[0];
            ST_START: bit_o = 1'b0;
            ST_DATA:  bit_o = word_sh[0];
            default:  bit_o = 1'b1;
        endcase

        d = q;
        if (take) d.word = in_data_i;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_PRE;
                    d.cnt  = CNT_W'(PRE_N - 1);
                    d.fidx = '0;
                    d.didx = '0;
                    d.done = 1'b0;
                    d.dw   = cfg_dw_i;
                    d.fr   = cfg_frames_i;
                    d.dv   = cfg_devs_i;
                    d.k    = cfg_k_i;
                end
            end
            ST_PRE: begin
                if (last) begin
                    d.st  = ST_LEN;
                    d.cnt = CNT_W'(LC_W - 1);
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_LEN: begin
                if (last) begin
                    d.st  = ST_SEP;
                    d.cnt = CNT_W'(SEP_BITS - 1);
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_SEP: begin
                if (last) d.st = take ? ST_START : ST_WAIT;
                else      d.cnt = q.cnt - CNT_W'(1);
            end
            ST_WAIT: begin
                if (take) d.st = ST_START;
            end
            ST_START: begin
                d.st  = ST_DATA;
                d.cnt = CNT_W'(q.dw - DWW'(1));
            end
            ST_DATA: begin
                if (last) begin
                    d.st  = ST_STOP;
                    d.cnt = CNT_W'(STOP_BITS - 1);
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_STOP: begin
                if (last) begin
                    if (more_frames) begin
                        d.fidx = q.fidx + FRAME_W'(1);
                        d.st   = take ? ST_START : ST_WAIT;
                    end else begin
                        d.st  = ST_POST;
                        d.cnt = CNT_W'(POST_BITS - 1);
                    end
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            ST_POST: begin
                if (last) begin
                    if (more_devs) begin
                        d.didx = q.didx + DEV_W'(1);
                        d.fidx = '0;
                        d.st   = take ? ST_START : ST_WAIT;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end else d.cnt = q.cnt - CNT_W'(1);
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready_o   = fetch;
    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign lat_dw_o     = q.dw;
    assign lat_frames_o = q.fr;
    assign lat_devs_o   = q.dv;
    assign lat_k_o      = q.k;

    // R8
    take_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (q.st == ST_START));

    // R6
    start_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START) |=> (q.st == ST_DATA));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(q.dw) && $stable(q.fr) && $stable(q.dv) && $stable(q.k)));

    // R10
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    dev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.didx < q.dv));

endmodule

// File: rtl/cfg_bitstream_framer.sv
module cfg_bitstream_framer #(
    parameter int DW_MAX  = 128,
    parameter int FRAME_W = 16,
    parameter int DEV_W   = 4,
    parameter int LC_W    = 24,
    parameter int DUMMY_N = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [$clog2(DW_MAX+1)-1:0] cfg_dw_i,
    input  logic [FRAME_W-1:0]          cfg_frames_i,
    input  logic [DEV_W-1:0]            cfg_devs_i,
    input  logic [2:0]                  cfg_k_i,
    input  logic                        in_valid_i,
    input  logic [DW_MAX-1:0]           in_data_i,
    output logic                        in_ready_o,
    output logic                        sdo_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [LC_W-1:0]             len_count_o
);

    localparam int DWW   = $clog2(DW_MAX + 1);
    localparam int HDR_N = DUMMY_N + cfg_framer_pkg::CODE_BITS + LC_W + cfg_framer_pkg::SEP_BITS;

    logic [DWW-1:0]     lat_dw;
    logic [FRAME_W-1:0] lat_frames;
    logic [DEV_W-1:0]   lat_devs;
    logic [2:0]         lat_k;
    logic               seq_bit;

    cfg_len_calc #(
        .DWW(DWW), .FRAME_W(FRAME_W), .DEV_W(DEV_W), .LC_W(LC_W), .HDR_N(HDR_N)
    ) u_len (
        .dw_i(lat_dw), .frames_i(lat_frames), .devs_i(lat_devs), .k_i(lat_k),
        .len_o(len_count_o)
    );

    cfg_bit_sequencer #(
        .DW_MAX(DW_MAX), .FRAME_W(FRAME_W), .DEV_W(DEV_W), .LC_W(LC_W), .DUMMY_N(DUMMY_N)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_dw_i(cfg_dw_i), .cfg_frames_i(cfg_frames_i), .cfg_devs_i(cfg_devs_i),
        .cfg_k_i(cfg_k_i), .len_i(len_count_o),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .bit_o(seq_bit), .busy_o(busy_o), .done_o(done_o),
        .lat_dw_o(lat_dw), .lat_frames_o(lat_frames), .lat_devs_o(lat_devs), .lat_k_o(lat_k)
    );

    cfg_sdo_stage u_sdo (
        .clk(clk), .rst_n(rst_n), .bit_i(seq_bit), .sdo_o(sdo_o)
    );

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> (sdo_o && !in_ready_o));

    // R4
    len_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((len_count_o[2:0] + lat_k) == 3'd0));

endmodule

// File: tb/tb_cfg_bitstream_framer.sv
module tb_cfg_bitstream_framer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [7:0]   cfg_dw_i = '0;
    logic [15:0]  cfg_frames_i = '0;
    logic [3:0]   cfg_devs_i = '0;
    logic [2:0]   cfg_k_i = '0;
    logic         in_valid_i = 1'b0;
    logic [127:0] in_data_i = '0;
    logic         in_ready_o, sdo_o, busy_o, done_o;
    logic [23:0]  len_count_o;

    int checks = 0;
    int errors = 0;

    bit           exp_q[$];
    bit           rx_q[$];
    logic [127:0] data_arr[64];
    int           stall_arr[64];

    always #4 clk = ~clk;

    cfg_bitstream_framer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_dw_i(cfg_dw_i), .cfg_frames_i(cfg_frames_i), .cfg_devs_i(cfg_devs_i),
        .cfg_k_i(cfg_k_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
        .len_count_o(len_count_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_len(int dw, int fr, int dv, int k);
        longint raw, rnd;
        raw = 40 + dv * (fr * (dw + 4) + 4) + dv;
        rnd = ((raw + 7) / 8) * 8;
        if (rnd - raw < k) rnd += 8;
        return rnd - k;
    endfunction

    function automatic int stall_of(int g);
        return (g < 64) ? stall_arr[g] : 0;
    endfunction

    function automatic void build(int dw, int fr, int dv, int k);
        longint lc;
        lc = exp_len(dw, fr, dv, k);
        exp_q.delete();
        repeat (8) exp_q.push_back(1'b1);
        exp_q.push_back(1'b0); exp_q.push_back(1'b0);
        exp_q.push_back(1'b1); exp_q.push_back(1'b0);
        for (int i = 23; i >= 0; i--) exp_q.push_back(lc[i]);
        repeat (4) exp_q.push_back(1'b1);
        for (int d = 0; d < dv; d++) begin
            for (int f = 0; f < fr; f++) begin
                int g;
                g = d * fr + f;
                repeat (stall_of(g)) exp_q.push_back(1'b1);
                exp_q.push_back(1'b0);
                for (int i = dw - 1; i >= 0; i--) exp_q.push_back(data_arr[g % 64][i]);
                repeat (3) exp_q.push_back(1'b1);
            end
            repeat (4) exp_q.push_back(1'b1);
        end
    endfunction

    task automatic feeder(int total);
        for (int g = 0; g < total; g++) begin
            in_data_i = data_arr[g % 64];
            if (stall_of(g) > 0) begin
                int c;
                c = 0;
                in_valid_i = 1'b0;
                while (c < stall_of(g)) begin
                    @(negedge clk);
                    if (in_ready_o) c++;
                end
                @(posedge clk); #1;
            end
            in_valid_i = 1'b1;
            do @(negedge clk); while (!in_ready_o);
            @(posedge clk); #1;
        end
        in_valid_i = 1'b0;
    endtask

    task automatic receiver(int dw, int fr, int dv, int k, string lreq, string sreq);
        int n, bad_a, bad_b, busy_bad;
        bit a, b;
        longint lc, hdr_lc;
        n = exp_q.size();
        bad_a = -1; bad_b = -1; busy_bad = 0;
        lc = exp_len(dw, fr, dv, k);
        rx_q.delete();
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2; a = sdo_o;
            @(posedge clk); #2; b = sdo_o;
            rx_q.push_back(b);
            if (i == 0) begin
                chk(len_count_o == lc[23:0], lreq, "length count", len_count_o, lc);
                chk(done_o == 1'b0, "R10", "done cleared by start", done_o, 0);
            end
            if (a !== exp_q[i] && bad_a < 0) bad_a = i;
            if (b !== exp_q[i] && bad_b < 0) bad_b = i;
            if (busy_o !== (i < n - 1)) busy_bad++;
        end
        chk(bad_a < 0, "R9", "bit before rising edge, first bad index", bad_a, -1);
        chk(bad_b < 0, sreq, "stream bit, first bad index", bad_b, -1);
        chk(busy_bad == 0, "R10", "busy span mismatches", busy_bad, 0);
        chk(done_o == 1'b1, "R10", "done after last bit", done_o, 1);
        // header pattern and serialised length read back from the line
        begin
            int hdr;
            hdr = 0;
            for (int i = 0; i < 12; i++) hdr = (hdr << 1) | int'(rx_q[i]);
            chk(hdr == 12'b1111_1111_0010, "R2", "preamble", hdr, 12'hFF2);
            hdr_lc = 0;
            for (int i = 12; i < 36; i++) hdr_lc = (hdr_lc << 1) | longint'(rx_q[i]);
            chk(hdr_lc == lc && rx_q[36] && rx_q[37] && rx_q[38] && rx_q[39],
                "R3", "serial length count", hdr_lc, lc);
        end
    endtask

    task automatic run_case(int dw, int fr, int dv, int k, bit midstart,
                            string lreq, string sreq);
        build(dw, fr, dv, k);
        @(posedge clk); #1;
        cfg_dw_i = 8'(dw); cfg_frames_i = 16'(fr); cfg_devs_i = 4'(dv); cfg_k_i = 3'(k);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        fork
            feeder(dv * fr);
            receiver(dw, fr, dv, k, lreq, sreq);
            begin
                if (midstart) begin
                    // R11: restart attempt with other settings mid-stream
                    repeat (50) @(posedge clk);
                    #1;
                    cfg_dw_i = 8'd3; cfg_frames_i = 16'd9; cfg_devs_i = 4'd2; cfg_k_i = 3'd2;
                    start_i = 1'b1;
                    @(posedge clk); #1;
                    start_i = 1'b0;
                end
            end
        join
        @(posedge clk); #2;
        chk(sdo_o == 1'b1 && !busy_o && !in_ready_o, "R1", "idle after stream",
            {sdo_o, busy_o, in_ready_o}, 3'b100);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            data_arr[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
            stall_arr[i] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        chk(sdo_o == 1'b1 && !busy_o && !in_ready_o && !done_o, "R1", "reset state",
            {sdo_o, busy_o, in_ready_o, done_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_case(8, 2, 1, 2, 1'b0, "R4", "R6");
        run_case(6, 1, 1, 2, 1'b0, "R5", "R6");   // increment 1 < K: +8
        run_case(7, 1, 1, 3, 1'b0, "R5", "R6");   // increment 0 < K: +8
        run_case(3, 1, 1, 4, 1'b0, "R5", "R6");   // increment equals K: no +8
        run_case(5, 2, 3, 3, 1'b0, "R4", "R7");

        // handshake stalls before selected frames
        stall_arr[0] = 2; stall_arr[2] = 1; stall_arr[3] = 3; stall_arr[5] = 1;
        run_case(10, 3, 2, 4, 1'b0, "R4", "R8");
        for (int i = 0; i < 64; i++) stall_arr[i] = 0;

        run_case(12, 4, 2, 2, 1'b1, "R4", "R11");

        // full-size example: 197 frames of 71 data bits, one device
        run_case(71, 197, 1, 4, 1'b0, "R4", "R6");
        chk(exp_len(71, 197, 1, 4) == 14820, "R4", "model example", exp_len(71, 197, 1, 4), 14820);
        chk(len_count_o == 24'd14820, "R4", "example length held", len_count_o, 14820);

        for (int t = 0; t < 6; t++) begin
            int dw, fr, dv, k;
            dw = 1 + int'($urandom_range(127));
            fr = 1 + int'($urandom_range(3));
            dv = 1 + int'($urandom_range(2));
            k  = 2 + int'($urandom_range(2));
            for (int i = 0; i < fr * dv; i++) stall_arr[i] = int'($urandom_range(2));
            run_case(dw, fr, dv, k, 1'b0, "R4", "R8");
            for (int i = 0; i < 64; i++) stall_arr[i] = 0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule